// File: doc/BRIEF.md
# Trap Entry Sequencer

This block sits in the execute stage and handles one decoded instruction at a time. It decides whether that instruction enters a system-call trap, enters an illegal-instruction trap, or passes through with no effect. The choice between a plain system call and its vectored form is made here, late in the pipeline. Decode only matches the 6-bit primary opcode. This block then tests one low bit of the instruction word. If that bit is clear, the instruction is the vectored form, and it becomes an illegal-instruction trap.

When a trap is taken, the block produces a one-cycle redirect carrying the trap vector. Over two consecutive cycles it drives a register-write port. The first write goes to the first save/restore register and carries the resume address. The second write goes to the second save/restore register and carries a copy of the machine state register. On the illegal cause, one flag bit of that copy is forced to 1. The block holds off new instructions until both writes are complete.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, `busy`, `redirect` and `rf_we` are all 0.
- R2: An instruction is a system-call candidate when `in_is_syscall` is 1 or its primary opcode (bits 31:26) equals 17. An accepted instruction that is neither a candidate nor flagged by `in_is_illegal` produces no redirect and no register write.
- R3: An accepted candidate with instruction bit 1 equal to 1 raises `redirect` in the cycle after acceptance, with `redirect_vec` = 0xC00.
- R4: An accepted candidate with instruction bit 1 equal to 0 takes the illegal-instruction trap: `redirect_vec` = 0x700.
- R5: Instruction bits 25:2 and bit 0, which include the level field, have no effect on the outcome.
- R6: In the redirect cycle, `rf_we`=1, `rf_sel`=0, and `rf_data` holds the instruction address plus 4 for a system call, or the instruction address itself for an illegal trap.
- R7: In the cycle after the redirect, `rf_we`=1, `rf_sel`=1, and `rf_data` holds the machine state value that was present when the instruction was accepted.
- R8: In that second write, bit 19 (counting from the least significant bit) is 1 on an illegal trap. On a system call the machine state value is copied unchanged.
- R9: When `in_is_illegal` is 1, the illegal trap is taken (vector 0x700, address not incremented), whatever the candidate decode says, and exactly one redirect is issued.
- R10: `busy` is 1 in both write cycles. An `in_valid` presented while `busy` is 1 is ignored, so no further redirect or write follows the second write.
- R11: `redirect` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present; accepted when `busy` is 0 |
| in_insn | input | 32 | Instruction word |
| in_addr | input | 64 | Address of the instruction |
| in_is_syscall | input | 1 | Decoded system-call flag |
| in_is_illegal | input | 1 | Decoded illegal-instruction flag |
| in_msr | input | 64 | Current machine state register |
| busy | output | 1 | Trap entry in progress; input not accepted |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirect_vec | output | 64 | Trap vector, valid with `redirect` |
| rf_we | output | 1 | Save/restore register write enable |
| rf_sel | output | 1 | 0 selects the first save register, 1 the second |
| rf_data | output | 64 | Write data |

## Verification
The hardest situation to reach from the ports is an instruction arriving while the second save write is still pending. In that situation, both the hold-off and the data capture are exercised at once. The sweep covers every primary opcode, both values of bit 1, and every combination of the two decode flags, with random values in the remaining fields. For every trap it keeps `in_valid` high with a fresh system-call decoy whose address and machine state differ from the original. The bench then checks that the second write still carries the captured value, and that no third cycle of activity follows.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
   typedef enum logic [1:0] {
      TS_IDLE   = 2'd0,
      TS_SAVE_A = 2'd1,
      TS_SAVE_B = 2'd2
   } ts_state_e;
endpackage

// File: rtl/trap_classify.sv
module trap_classify #(
   parameter int ILEN             = 32,
   parameter int OPC_W            = 6,
   parameter int OPC_SYSCALL      = 17,
   parameter int SEL_BIT          = 1,
   parameter bit LOCAL_OPC_DECODE = 1'b1
) (
   input  logic [ILEN-1:0] insn,
   input  logic            dec_sc,
   input  logic            dec_ill,
   output logic            take,
   output logic            is_ill
);
   localparam int OPC_LSB = ILEN - OPC_W;

   logic opc_hit;
   logic cand;
   logic unused_insn;

   generate
      if (LOCAL_OPC_DECODE) begin : g_local_opc
         assign opc_hit = (insn[ILEN-1:OPC_LSB] == OPC_W'(OPC_SYSCALL));
      end else begin : g_flag_only
         assign opc_hit = 1'b0;
      end
   endgenerate

   assign unused_insn = ^insn;

   always_comb begin
      cand   = dec_sc | opc_hit;
      is_ill = dec_ill | (cand & ~insn[SEL_BIT]);
      take   = cand | dec_ill;
   end
endmodule

// File: rtl/trap_payload.sv
module trap_payload #(
   parameter int XLEN    = 64,
   parameter int VEC_SC  = 'hC00,
   parameter int VEC_ILL = 'h700,
   parameter int ILL_BIT = 19,
   parameter int STEP    = 4
) (
   input  logic            is_ill,
   input  logic [XLEN-1:0] addr,
   input  logic [XLEN-1:0] msr,
   output logic [XLEN-1:0] vec,
   output logic [XLEN-1:0] save0,
   output logic [XLEN-1:0] save1
);
   localparam logic [XLEN-1:0] MARK = XLEN'(1) << ILL_BIT;

   always_comb begin
      vec   = is_ill ? XLEN'(VEC_ILL) : XLEN'(VEC_SC);
      save0 = is_ill ? addr : addr + XLEN'(STEP);
      save1 = is_ill ? (msr | MARK) : msr;
   end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
   import trap_seq_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int VEC_SC  = 'hC00,
   parameter int VEC_ILL = 'h700,
   parameter int ILL_BIT = 19
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            valid,
   input  logic            take,
   input  logic [XLEN-1:0] vec,
   input  logic [XLEN-1:0] save0,
   input  logic [XLEN-1:0] save1,
   output logic            busy,
   output logic            redirect,
   output logic [XLEN-1:0] redirect_vec,
   output logic            rf_we,
   output logic            rf_sel,
   output logic [XLEN-1:0] rf_data
);
   ts_state_e       state;
   logic [XLEN-1:0] vec_q;
   logic [XLEN-1:0] save0_q;
   logic [XLEN-1:0] save1_q;
   logic            accept;

   assign accept = (state == TS_IDLE) && valid && take;

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= TS_IDLE;
      end else begin
         case (state)
            TS_IDLE:   if (accept) state <= TS_SAVE_A;
            TS_SAVE_A: state <= TS_SAVE_B;
            TS_SAVE_B: state <= TS_IDLE;
            default:   state <= TS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         vec_q   <= vec;
         save0_q <= save0;
         save1_q <= save1;
      end
   end

   always_comb begin
      busy         = (state != TS_IDLE);
      redirect     = (state == TS_SAVE_A);
      redirect_vec = redirect ? vec_q : '0;
      rf_we        = (state == TS_SAVE_A) || (state == TS_SAVE_B);
      rf_sel       = (state == TS_SAVE_B);
      case (state)
         TS_SAVE_A: rf_data = save0_q;
         TS_SAVE_B: rf_data = save1_q;
         default:   rf_data = '0;
      endcase
   end

   AST_ONE_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      redirect |=> !redirect); // R11
   AST_REDIRECT_FIRST_WRITE: assert property (@(posedge clk) disable iff (rst)
      redirect |-> (rf_we && !rf_sel)); // R6
   AST_PAIRED_WRITE: assert property (@(posedge clk) disable iff (rst)
      (rf_we && !rf_sel) |=> (rf_we && rf_sel)); // R7
   AST_ACCEPT_REDIRECT: assert property (@(posedge clk) disable iff (rst)
      (valid && take && !busy) |=> redirect); // R3
   AST_VEC_KNOWN: assert property (@(posedge clk) disable iff (rst)
      redirect |-> (redirect_vec == XLEN'(VEC_SC) || redirect_vec == XLEN'(VEC_ILL))); // R4
   AST_ILL_MARK: assert property (@(posedge clk) disable iff (rst)
      (rf_we && rf_sel && $past(redirect_vec) == XLEN'(VEC_ILL)) |-> rf_data[ILL_BIT]); // R8
   AST_NO_THIRD_CYCLE: assert property (@(posedge clk) disable iff (rst)
      rf_sel |=> (!busy && !rf_we)); // R10
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
   parameter int XLEN             = 64,
   parameter int ILEN             = 32,
   parameter int OPC_W            = 6,
   parameter int OPC_SYSCALL      = 17,
   parameter int SEL_BIT          = 1,
   parameter int VEC_SC           = 'hC00,
   parameter int VEC_ILL          = 'h700,
   parameter int ILL_BIT          = 19,
   parameter int STEP             = 4,
   parameter bit LOCAL_OPC_DECODE = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [31:0]     in_insn,
   input  logic [63:0]     in_addr,
   input  logic            in_is_syscall,
   input  logic            in_is_illegal,
   input  logic [63:0]     in_msr,
   output logic            busy,
   output logic            redirect,
   output logic [63:0]     redirect_vec,
   output logic            rf_we,
   output logic            rf_sel,
   output logic [63:0]     rf_data
);
   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("trap_entry_seq: XLEN must match the 64-bit ports");
      end
      if (ILEN != 32) begin : g_bad_ilen
         $error("trap_entry_seq: ILEN must match the 32-bit instruction port");
      end
      if (ILL_BIT >= XLEN) begin : g_bad_mark
         $error("trap_entry_seq: ILL_BIT outside the state word");
      end
      if (SEL_BIT >= ILEN - OPC_W) begin : g_bad_sel
         $error("trap_entry_seq: SEL_BIT overlaps the primary opcode");
      end
      if (OPC_SYSCALL >= (1 << OPC_W)) begin : g_bad_opc
         $error("trap_entry_seq: OPC_SYSCALL does not fit OPC_W bits");
      end
   endgenerate

   logic            take;
   logic            is_ill;
   logic [XLEN-1:0] vec;
   logic [XLEN-1:0] save0;
   logic [XLEN-1:0] save1;

   trap_classify #(
      .ILEN(ILEN), .OPC_W(OPC_W), .OPC_SYSCALL(OPC_SYSCALL),
      .SEL_BIT(SEL_BIT), .LOCAL_OPC_DECODE(LOCAL_OPC_DECODE)
   ) u_classify (
      .insn(in_insn), .dec_sc(in_is_syscall), .dec_ill(in_is_illegal),
      .take(take), .is_ill(is_ill)
   );

   trap_payload #(
      .XLEN(XLEN), .VEC_SC(VEC_SC), .VEC_ILL(VEC_ILL),
      .ILL_BIT(ILL_BIT), .STEP(STEP)
   ) u_payload (
      .is_ill(is_ill), .addr(in_addr), .msr(in_msr),
      .vec(vec), .save0(save0), .save1(save1)
   );

   trap_seq #(
      .XLEN(XLEN), .VEC_SC(VEC_SC), .VEC_ILL(VEC_ILL), .ILL_BIT(ILL_BIT)
   ) u_seq (
      .clk(clk), .rst(rst), .valid(in_valid), .take(take),
      .vec(vec), .save0(save0), .save1(save1),
      .busy(busy), .redirect(redirect), .redirect_vec(redirect_vec),
      .rf_we(rf_we), .rf_sel(rf_sel), .rf_data(rf_data)
   );
endmodule

// File: tb/sim_trap_entry_seq.sv
`timescale 1ns/1ps
module sim_trap_entry_seq;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] in_insn;
   logic [63:0] in_addr;
   logic        in_is_syscall;
   logic        in_is_illegal;
   logic [63:0] in_msr;
   logic        busy;
   logic        redirect;
   logic [63:0] redirect_vec;
   logic        rf_we;
   logic        rf_sel;
   logic [63:0] rf_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   trap_entry_seq u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
      .in_addr(in_addr), .in_is_syscall(in_is_syscall),
      .in_is_illegal(in_is_illegal), .in_msr(in_msr),
      .busy(busy), .redirect(redirect), .redirect_vec(redirect_vec),
      .rf_we(rf_we), .rf_sel(rf_sel), .rf_data(rf_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_insn = '0; in_addr = '0;
      in_is_syscall = 1'b0; in_is_illegal = 1'b0; in_msr = '0;
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", 64'(busy), 64'd0);
      chk("R1 rf_we in reset", 64'(rf_we), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 redirect after reset", 64'(redirect), 64'd0);
      chk("R1 rf_we after reset", 64'(rf_we), 64'd0);
      chk("R1 busy after reset", 64'(busy), 64'd0);

      for (int opc = 0; opc < 64; opc++) begin
         for (int b1 = 0; b1 < 2; b1++) begin
            for (int sc = 0; sc < 2; sc++) begin
               for (int il = 0; il < 2; il++) begin
                  logic [31:0] r;
                  logic [31:0] insn;
                  logic [63:0] addr, msr, e_vec, e_s0, e_s1;
                  logic        cand, ill, trap;
                  string       tag;
                  r    = $urandom();
                  insn = {opc[5:0], r[25:2], b1[0], r[0]};
                  addr = {$urandom(), $urandom()} & ~64'h3;
                  msr  = {$urandom(), $urandom()};
                  cand = (sc != 0) || (opc == 17);
                  ill  = (il != 0) || (cand && b1 == 0);
                  trap = cand || (il != 0);
                  e_vec = ill ? 64'h700 : 64'hC00;
                  e_s0  = ill ? addr : addr + 64'd4;
                  e_s1  = ill ? (msr | 64'h80000) : msr;
                  if (il != 0 && cand) tag = "R9";
                  else if (ill) tag = "R4 R5";
                  else tag = "R3 R5";

                  in_valid = 1'b1; in_insn = insn; in_addr = addr;
                  in_is_syscall = sc[0]; in_is_illegal = il[0]; in_msr = msr;
                  @(negedge clk);
                  if (trap) begin
                     chk({tag, " redirect"}, 64'(redirect), 64'd1);
                     chk({tag, " vector"}, redirect_vec, e_vec);
                     chk("R6 first write enable", 64'({rf_we, rf_sel}), 64'b10);
                     chk({"R6 ", tag, " first save data"}, rf_data, e_s0);
                     chk("R10 busy first write", 64'(busy), 64'd1);
                     in_insn = {6'd17, r[25:2] ^ 24'hA5A5A5, 1'b1, 1'b1};
                     in_addr = ~addr; in_msr = ~msr;
                     in_is_syscall = 1'b1; in_is_illegal = 1'b0;
                     @(negedge clk);
                     chk("R11 redirect pulse", 64'(redirect), 64'd0);
                     chk("R7 second write enable", 64'({rf_we, rf_sel}), 64'b11);
                     chk({"R7 R8 ", tag, " second save data"}, rf_data, e_s1);
                     chk("R10 busy second write", 64'(busy), 64'd1);
                     in_valid = 1'b0;
                     @(negedge clk);
                     chk("R10 decoy ignored redirect", 64'(redirect), 64'd0);
                     chk("R10 decoy ignored write", 64'(rf_we), 64'd0);
                     chk("R10 busy released", 64'(busy), 64'd0);
                  end else begin
                     chk("R2 no redirect", 64'(redirect), 64'd0);
                     chk("R2 no write", 64'(rf_we), 64'd0);
                     chk("R2 not busy", 64'(busy), 64'd0);
                     in_valid = 1'b0;
                     @(negedge clk);
                  end
               end
            end
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule